// File: doc/BRIEF.md
# First-Fault Load Element Filter

This block sits beside one load micro-operation of a unit-stride vector load whose semantics are "trap only if the very first element faults". When the memory system answers a micro-operation, the block turns any reported faulting address into an element position relative to the micro-operation's base address. It then decides whether the fault must be raised as a trap, or whether it can be dropped so that a later stage shortens the vector length to the elements that loaded cleanly.

A fault is raised only when it lands on element zero of the first micro-operation. Any fault further along is suppressed, and a trim flag tells the downstream length trimmer where the clean run ends. Faults that carry no faulting address are passed through as traps. For every element of the destination register the block also produces a write enable. The write enable combines the mask, the active element count and the fault position, so that elements at or past the fault keep their old contents.

Results are registered. They are presented with a one-cycle valid strobe and held until the next response or the next issue. Issuing a new micro-operation clears the trim and trap state.

Top module: `ff_load_filter`

## Requirements
- R1: The fault position equals (fault address − base address) shifted right by log2 of the element size in bytes. The width code is 0→8, 1→16, 2→32 and 3→64 bits. The position is clamped to the active element count.
- R2: With fault kind 0 (none), the registered fault position equals the active element count, and both trim and trap are low.
- R3: With fault kind 1 (address) or 2 (page table), a nonzero micro-operation index or a nonzero raw position gives trap low and trim high. Trim and trap are never high together.
- R4: With fault kind 1 or 2, micro-operation index 0 and raw position 0, trap is high, trim is low and the trap kind equals the input kind.
- R5: Fault kind 3 (other) passes through unchanged: trap high, trap kind 3, trim low, and a fault position equal to the active count.
- R6: Write enable bit i is high only when (all_active_i or mask_i[i]) holds, i is below the active count, i is below the fault position, and no trap is raised.
- R7: Results appear in the cycle after resp_valid_i is sampled. res_valid_o is high for exactly that one cycle, and the other outputs hold until the next response or issue.
- R8: issue_i without a response clears valid, trap, trim and the write enables, and loads the fault position with active_cnt_i. When issue_i and resp_valid_i coincide, the response result wins.
- R9: An address-carrying fault with a fault address below the base address is illegal.
- R10: After reset, all outputs are zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| issue_i | input | 1 | A new micro-operation is issued |
| resp_valid_i | input | 1 | Memory response for the current micro-operation |
| base_addr_i | input | ADDR_W | Base address of the micro-operation |
| micro_idx_i | input | MIDX_W | Index of the micro-operation in its sequence |
| active_cnt_i | input | CNT_W | Active element count of the micro-operation |
| ew_code_i | input | 2 | Element width code (0:8, 1:16, 2:32, 3:64 bits) |
| fault_kind_i | input | 2 | 0 none, 1 address, 2 page table, 3 other |
| fault_addr_i | input | ADDR_W | Faulting address (kinds 1 and 2) |
| all_active_i | input | 1 | Operation is unmasked |
| mask_i | input | ELEMS | Per-element mask bits |
| res_valid_o | output | 1 | One-cycle strobe for a new result |
| trap_o | output | 1 | Fault is taken as a trap |
| trap_kind_o | output | 2 | Kind of the trapping fault |
| trim_o | output | 1 | Fault suppressed; vector length must be trimmed |
| fault_idx_o | output | CNT_W | Element position of the fault, or the active count |
| wr_en_o | output | ELEMS | Per-element destination write enable |

## Verification
A new issue and a memory response can land in the same cycle. In that case the clearing action of the issue competes with the registering of the response verdict. The bench provokes this by first leaving a suppressed-fault result with trim high in the output registers, then raising issue_i and resp_valid_i on the same edge with a fresh no-fault response. It judges the outcome by requiring res_valid_o high and fault_idx_o equal to the new active count. Trim must also be low, which shows that the response decided the state and that the old trim was not held over.

// File: rtl/ffl_pkg.sv
package ffl_pkg;

    typedef enum logic [1:0] {
        FK_NONE  = 2'd0,
        FK_ADDR  = 2'd1,
        FK_PTW   = 2'd2,
        FK_OTHER = 2'd3
    } fault_kind_e;

    typedef enum logic [1:0] {
        EW_8  = 2'd0,
        EW_16 = 2'd1,
        EW_32 = 2'd2,
        EW_64 = 2'd3
    } ew_code_e;

    typedef struct packed {
        logic        trap;
        logic        trim;
        fault_kind_e kind;
    } verdict_t;

    function automatic logic carries_addr(fault_kind_e k);
        return (k == FK_ADDR) || (k == FK_PTW);
    endfunction

    // Byte-size shift for an element width code equals the code itself.
    function automatic logic [1:0] size_shift(ew_code_e ew);
        return 2'(ew);
    endfunction

endpackage

// File: rtl/ffl_index_calc.sv
module ffl_index_calc
    import ffl_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int CNT_W  = 5
) (
    input  logic [ADDR_W-1:0] base_addr,
    input  logic [ADDR_W-1:0] fault_addr,
    input  ew_code_e          ew,
    input  logic [CNT_W-1:0]  active_cnt,
    input  logic              has_addr,
    output logic [CNT_W-1:0]  elem_idx,
    output logic              raw_zero
);
    logic [ADDR_W-1:0] byte_off;
    logic [ADDR_W-1:0] elem_off;
    logic [ADDR_W-1:0] cnt_ext;

    always_comb begin
        byte_off = fault_addr - base_addr;
        elem_off = byte_off >> size_shift(ew);
        cnt_ext  = ADDR_W'(active_cnt);
        raw_zero = has_addr && (elem_off == '0);
        if (!has_addr || (elem_off >= cnt_ext)) begin
            elem_idx = active_cnt;
        end else begin
            elem_idx = elem_off[CNT_W-1:0];
        end
    end
endmodule

// File: rtl/ffl_fault_decide.sv
module ffl_fault_decide
    import ffl_pkg::*;
#(
    parameter int MIDX_W = 3
) (
    input  fault_kind_e       kind,
    input  logic [MIDX_W-1:0] micro_idx,
    input  logic              raw_zero,
    output verdict_t          verdict
);
    always_comb begin
        verdict = '{trap: 1'b0, trim: 1'b0, kind: FK_NONE};
        unique case (kind)
            FK_NONE: ;
            FK_OTHER: begin
                verdict.trap = 1'b1;
                verdict.kind = kind;
            end
            default: begin
                if ((micro_idx == '0) && raw_zero) begin
                    verdict.trap = 1'b1;
                    verdict.kind = kind;
                end else begin
                    verdict.trim = 1'b1;
                end
            end
        endcase
    end
endmodule

// File: rtl/ffl_wen_gen.sv
module ffl_wen_gen #(
    parameter int ELEMS = 16,
    parameter int CNT_W = 5
) (
    input  logic             all_active,
    input  logic [ELEMS-1:0] mask,
    input  logic [CNT_W-1:0] active_cnt,
    input  logic [CNT_W-1:0] fault_idx,
    input  logic             trap,
    output logic [ELEMS-1:0] wr_en
);
    localparam int IW = (CNT_W > $clog2(ELEMS)) ? CNT_W : $clog2(ELEMS) + 1;

    for (genvar g = 0; g < ELEMS; g++) begin : g_elem
        localparam logic [IW-1:0] POS = IW'(g);
        logic below_cnt;
        logic below_fault;
        assign below_cnt   = POS < IW'(active_cnt);
        assign below_fault = POS < IW'(fault_idx);
        assign wr_en[g] = (all_active || mask[g]) && below_cnt && below_fault && !trap;
    end
endmodule

// File: rtl/ff_load_filter.sv
module ff_load_filter
    import ffl_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int MIDX_W = 3,
    parameter int ELEMS  = 16,
    parameter int CNT_W  = $clog2(ELEMS + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              issue_i,
    input  logic              resp_valid_i,
    input  logic [ADDR_W-1:0] base_addr_i,
    input  logic [MIDX_W-1:0] micro_idx_i,
    input  logic [CNT_W-1:0]  active_cnt_i,
    input  logic [1:0]        ew_code_i,
    input  logic [1:0]        fault_kind_i,
    input  logic [ADDR_W-1:0] fault_addr_i,
    input  logic              all_active_i,
    input  logic [ELEMS-1:0]  mask_i,
    output logic              res_valid_o,
    output logic              trap_o,
    output logic [1:0]        trap_kind_o,
    output logic              trim_o,
    output logic [CNT_W-1:0]  fault_idx_o,
    output logic [ELEMS-1:0]  wr_en_o
);
    fault_kind_e       kind;
    ew_code_e          ew;
    logic              has_addr;
    logic [CNT_W-1:0]  elem_idx;
    logic              raw_zero;
    verdict_t          verdict;
    logic [ELEMS-1:0]  wen_next;

    assign kind     = fault_kind_e'(fault_kind_i);
    assign ew       = ew_code_e'(ew_code_i);
    assign has_addr = carries_addr(kind);

    ffl_index_calc #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_idx (
        .base_addr (base_addr_i),
        .fault_addr(fault_addr_i),
        .ew        (ew),
        .active_cnt(active_cnt_i),
        .has_addr  (has_addr),
        .elem_idx  (elem_idx),
        .raw_zero  (raw_zero)
    );

    ffl_fault_decide #(.MIDX_W(MIDX_W)) u_dec (
        .kind     (kind),
        .micro_idx(micro_idx_i),
        .raw_zero (raw_zero),
        .verdict  (verdict)
    );

    ffl_wen_gen #(.ELEMS(ELEMS), .CNT_W(CNT_W)) u_wen (
        .all_active(all_active_i),
        .mask      (mask_i),
        .active_cnt(active_cnt_i),
        .fault_idx (elem_idx),
        .trap      (verdict.trap),
        .wr_en     (wen_next)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            res_valid_o <= 1'b0;
            trap_o      <= 1'b0;
            trap_kind_o <= 2'd0;
            trim_o      <= 1'b0;
            fault_idx_o <= '0;
            wr_en_o     <= '0;
        end else if (resp_valid_i) begin
            res_valid_o <= 1'b1;
            trap_o      <= verdict.trap;
            trap_kind_o <= 2'(verdict.kind);
            trim_o      <= verdict.trim;
            fault_idx_o <= elem_idx;
            wr_en_o     <= wen_next;
        end else if (issue_i) begin
            res_valid_o <= 1'b0;
            trap_o      <= 1'b0;
            trap_kind_o <= 2'd0;
            trim_o      <= 1'b0;
            fault_idx_o <= active_cnt_i;
            wr_en_o     <= '0;
        end else begin
            res_valid_o <= 1'b0;
        end
    end

    // R9: an address-carrying fault may never point below the base address
    assert_addr_not_below_base_R9: assert property (@(posedge clk) disable iff (rst)
        (resp_valid_i && has_addr) |-> (fault_addr_i >= base_addr_i));

    // R3: suppression and trap are exclusive
    assert_trim_trap_excl_R3: assert property (@(posedge clk) disable iff (rst)
        !(trim_o && trap_o));

    // R6: a taken trap writes no element
    assert_trap_no_write_R6: assert property (@(posedge clk) disable iff (rst)
        trap_o |-> (wr_en_o == '0));

    // R6: never more writes than the fault position allows
    assert_wen_bound_R6: assert property (@(posedge clk) disable iff (rst)
        ($countones(wr_en_o) <= int'(fault_idx_o)));

    // R7: a result strobe only follows a sampled response
    assert_valid_after_resp_R7: assert property (@(posedge clk) disable iff (rst)
        res_valid_o |-> $past(resp_valid_i));

    // R8: issue alone clears the verdict
    assert_issue_clears_R8: assert property (@(posedge clk) disable iff (rst)
        (issue_i && !resp_valid_i) |=> (!res_valid_o && !trim_o && !trap_o && wr_en_o == '0));

    // R2: a clean response reports the full active count
    assert_clean_full_count_R2: assert property (@(posedge clk) disable iff (rst)
        (resp_valid_i && fault_kind_i == 2'd0) |=>
            (!trim_o && !trap_o && fault_idx_o == $past(active_cnt_i)));
endmodule

// File: tb/ff_load_filter_tb.sv
module ff_load_filter_tb;
    localparam int ADDR_W = 32;
    localparam int MIDX_W = 3;
    localparam int ELEMS  = 16;
    localparam int CNT_W  = $clog2(ELEMS + 1);

    logic              clk = 1'b0;
    logic              rst;
    logic              issue_i;
    logic              resp_valid_i;
    logic [ADDR_W-1:0] base_addr_i;
    logic [MIDX_W-1:0] micro_idx_i;
    logic [CNT_W-1:0]  active_cnt_i;
    logic [1:0]        ew_code_i;
    logic [1:0]        fault_kind_i;
    logic [ADDR_W-1:0] fault_addr_i;
    logic              all_active_i;
    logic [ELEMS-1:0]  mask_i;
    logic              res_valid_o;
    logic              trap_o;
    logic [1:0]        trap_kind_o;
    logic              trim_o;
    logic [CNT_W-1:0]  fault_idx_o;
    logic [ELEMS-1:0]  wr_en_o;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #5 clk = ~clk;

    ff_load_filter #(.ADDR_W(ADDR_W), .MIDX_W(MIDX_W), .ELEMS(ELEMS), .CNT_W(CNT_W)) u_dut (
        .clk(clk), .rst(rst), .issue_i(issue_i), .resp_valid_i(resp_valid_i),
        .base_addr_i(base_addr_i), .micro_idx_i(micro_idx_i), .active_cnt_i(active_cnt_i),
        .ew_code_i(ew_code_i), .fault_kind_i(fault_kind_i), .fault_addr_i(fault_addr_i),
        .all_active_i(all_active_i), .mask_i(mask_i), .res_valid_o(res_valid_o),
        .trap_o(trap_o), .trap_kind_o(trap_kind_o), .trim_o(trim_o),
        .fault_idx_o(fault_idx_o), .wr_en_o(wr_en_o)
    );

    task automatic chk(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [ELEMS-1:0] model_wen(input logic all, input logic [ELEMS-1:0] m,
                                                    input int cnt, input int fidx, input logic trap);
        logic [ELEMS-1:0] r = '0;
        for (int i = 0; i < ELEMS; i++)
            if (!trap && i < cnt && i < fidx && (all || m[i])) r[i] = 1'b1;
        return r;
    endfunction

    // Inputs change on the falling edge; results are sampled on the next falling edge.
    task automatic respond(input logic [31:0] base, input int midx, input int cnt, input int ew,
                           input int kind, input logic [31:0] fa, input logic all,
                           input logic [ELEMS-1:0] m, input logic with_issue);
        @(negedge clk);
        base_addr_i  = base;
        micro_idx_i  = MIDX_W'(midx);
        active_cnt_i = CNT_W'(cnt);
        ew_code_i    = 2'(ew);
        fault_kind_i = 2'(kind);
        fault_addr_i = fa;
        all_active_i = all;
        mask_i       = m;
        resp_valid_i = 1'b1;
        issue_i      = with_issue;
        @(negedge clk);
        resp_valid_i = 1'b0;
        issue_i      = 1'b0;
    endtask

    task automatic t_reset;
        chk("R10", "valid", 64'(res_valid_o), 0);
        chk("R10", "trap", 64'(trap_o), 0);
        chk("R10", "trim", 64'(trim_o), 0);
        chk("R10", "idx", 64'(fault_idx_o), 0);
        chk("R10", "wen", 64'(wr_en_o), 0);
    endtask

    task automatic t_no_fault;
        respond(32'h2000, 1, 10, 2, 0, 32'h0, 1'b1, '0, 1'b0);
        chk("R2", "valid", 64'(res_valid_o), 1);
        chk("R2", "idx", 64'(fault_idx_o), 10);
        chk("R2", "trim", 64'(trim_o), 0);
        chk("R2", "trap", 64'(trap_o), 0);
        chk("R6", "wen", 64'(wr_en_o), 64'(model_wen(1'b1, '0, 10, 10, 1'b0)));
    endtask

    task automatic t_widths;
        for (int ew = 0; ew < 4; ew++) begin
            logic [31:0] fa = 32'h1000 + (32'd5 << ew) + ((ew != 0) ? 32'd1 : 32'd0);
            respond(32'h1000, 0, 16, ew, 1, fa, 1'b1, '0, 1'b0);
            chk("R1", "idx", 64'(fault_idx_o), 5);
            chk("R3", "trim", 64'(trim_o), 1);
            chk("R3", "trap", 64'(trap_o), 0);
            chk("R6", "wen", 64'(wr_en_o), 64'h1F);
        end
    endtask

    task automatic t_first_elem_trap;
        respond(32'h3000, 0, 8, 1, 2, 32'h3001, 1'b1, '0, 1'b0);
        chk("R4", "trap", 64'(trap_o), 1);
        chk("R4", "kind", 64'(trap_kind_o), 2);
        chk("R4", "trim", 64'(trim_o), 0);
        chk("R6", "wen", 64'(wr_en_o), 0);
    endtask

    task automatic t_later_micro_elem0;
        respond(32'h4000, 2, 8, 0, 1, 32'h4000, 1'b1, '0, 1'b0);
        chk("R3", "trap", 64'(trap_o), 0);
        chk("R3", "trim", 64'(trim_o), 1);
        chk("R1", "idx", 64'(fault_idx_o), 0);
        chk("R6", "wen", 64'(wr_en_o), 0);
    endtask

    task automatic t_other_fault;
        respond(32'h5000, 0, 8, 0, 3, 32'h5003, 1'b1, '0, 1'b0);
        chk("R5", "trap", 64'(trap_o), 1);
        chk("R5", "kind", 64'(trap_kind_o), 3);
        chk("R5", "trim", 64'(trim_o), 0);
        chk("R5", "idx", 64'(fault_idx_o), 8);
        chk("R5", "wen", 64'(wr_en_o), 0);
    endtask

    task automatic t_masked;
        respond(32'h6000, 1, 12, 0, 1, 32'h6007, 1'b0, 16'hA5A5, 1'b0);
        chk("R6", "idx", 64'(fault_idx_o), 7);
        chk("R6", "wen", 64'(wr_en_o), 64'(model_wen(1'b0, 16'hA5A5, 12, 7, 1'b0)));
        chk("R6", "wen_lit", 64'(wr_en_o), 64'h0025);
    endtask

    task automatic t_clamp;
        respond(32'h7000, 0, 4, 0, 1, 32'h7064, 1'b1, '0, 1'b0);
        chk("R1", "clamp_idx", 64'(fault_idx_o), 4);
        chk("R3", "trim", 64'(trim_o), 1);
        chk("R6", "wen", 64'(wr_en_o), 64'h000F);
        @(negedge clk);
        chk("R7", "pulse", 64'(res_valid_o), 0);
        chk("R7", "hold_trim", 64'(trim_o), 1);
        chk("R7", "hold_idx", 64'(fault_idx_o), 4);
    endtask

    task automatic t_issue_clear;
        @(negedge clk);
        active_cnt_i = CNT_W'(6);
        issue_i      = 1'b1;
        @(negedge clk);
        issue_i = 1'b0;
        chk("R8", "valid", 64'(res_valid_o), 0);
        chk("R8", "trim", 64'(trim_o), 0);
        chk("R8", "trap", 64'(trap_o), 0);
        chk("R8", "idx", 64'(fault_idx_o), 6);
        chk("R8", "wen", 64'(wr_en_o), 0);
    endtask

    task automatic t_issue_with_resp;
        respond(32'h8000, 3, 16, 0, 1, 32'h8002, 1'b1, '0, 1'b0);
        chk("R3", "pre_trim", 64'(trim_o), 1);
        respond(32'h9000, 0, 9, 0, 0, 32'h0, 1'b1, '0, 1'b1);
        chk("R8", "valid", 64'(res_valid_o), 1);
        chk("R8", "idx", 64'(fault_idx_o), 9);
        chk("R8", "trim", 64'(trim_o), 0);
        chk("R8", "wen", 64'(wr_en_o), 64'h01FF);
    endtask

    initial begin
        #(200000 * 10);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; issue_i = 1'b0; resp_valid_i = 1'b0;
        base_addr_i = '0; micro_idx_i = '0; active_cnt_i = '0; ew_code_i = '0;
        fault_kind_i = '0; fault_addr_i = '0; all_active_i = 1'b0; mask_i = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_no_fault();
        t_widths();
        t_first_elem_trap();
        t_later_micro_elem0();
        t_other_fault();
        t_masked();
        t_clamp();
        t_issue_clear();
        t_issue_with_resp();
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule